// File: doc/BRIEF.md
# Multi-bit ECC lookup filter

This block sits beside an L2 cache and decides, for every 64-bit subblock access, whether the slow multi-bit error-correction path has to be used. Blocks found to hold defective cells during memory test are recorded in a fully associative defect store. Each entry of that store holds a location tag and the multi-bit check bits for that location. Accesses to any other address take the normal single-error path, which is outside this block.

Two small buffers keep most accesses away from the defect store and the codec. A clean-address filter remembers recent addresses that the defect store did not hold, and a hit there answers at once. A corrected-data buffer keeps the decoded contents of recently read defective subblocks, so repeat reads need no decode. Both buffers evict their least recently used entry. Reads of defective subblocks that miss the buffer, and all writes to defective subblocks, are sent to an external encoder/decoder over a valid/ready command channel. The result comes back tens of cycles later, so the response has variable latency. Only one request is in flight at a time.

Top module: `mecc_filter`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `cx_valid` are 0.
- R2: An access whose address is in neither the filter nor the defect store responds in the next cycle with `rsp_code` 1 and places the address in the filter. A later access to that address responds in the next cycle with `rsp_code` 0. Neither access sends a codec command, and `rsp_rdata` is 0 for both codes.
- R3: When the filter is full, a new clean address replaces the filter entry that was least recently hit or filled.
- R4: A read of a defective address that is not buffered issues a decode command (`cx_encode` 0) carrying the address and that entry's stored check bits. One cycle after `cr_valid`, the response gives `rsp_code` 3 with `cr_rdata`, and the data is placed in the corrected-data buffer.
- R5: A read of a buffered address responds in the next cycle with `rsp_code` 2 and the buffered data, and sends no codec command.
- R6: When the corrected-data buffer is full, a new decode result replaces its least recently used entry.
- R7: A write to a defective address issues an encode command (`cx_encode` 1) with the write data. The returned `cr_chk` replaces that entry's check bits, and the response gives `rsp_code` 4.
- R8: A write to a buffered address updates the buffered copy in the cycle it is accepted, so a later read returns the new data with `rsp_code` 2.
- R9: `req_ready` stays 0 from the acceptance of a codec-bound request until its response. `cx_valid` stays high with stable fields until `cx_ready`.
- R10: A load pulse (`ld_valid`) writes a tag and check bits into defect-store slot `ld_idx` and marks that slot defective.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load one defect-store slot |
| ld_idx | input | $clog2(TN) | Slot to load |
| ld_tag | input | AW | Defective subblock address |
| ld_chk | input | CW | Initial check bits |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Subblock address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 3 | 0 filter hit, 1 clean after search, 2 buffered, 3 decoded, 4 encoded |
| rsp_rdata | output | DW | Corrected read data for codes 2 and 3, else 0 |
| cx_valid | output | 1 | Codec command valid |
| cx_ready | input | 1 | Codec accepts command |
| cx_encode | output | 1 | 1 = encode, 0 = decode |
| cx_addr | output | AW | Subblock address for the codec |
| cx_wdata | output | DW | Data to encode |
| cx_chk | output | CW | Stored check bits for a decode |
| cr_valid | input | 1 | Codec result pulse |
| cr_rdata | input | DW | Corrected data from a decode |
| cr_chk | input | CW | New check bits from an encode |

## Verification
A write to a subblock held in the corrected-data buffer does two things in its acceptance cycle: it rewrites the buffered copy and it starts an encode. The bench brings this about by decoding a defective subblock, then writing new data to it. It judges the result in three ways: the write must produce an encode command and `rsp_code` 4, and a following read must return the new data with `rsp_code` 2 and no codec command at all.

// File: rtl/mecc_filter.sv
module mecc_filter #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16,
  parameter int FN = 8,
  parameter int PN = 4,
  parameter int TN = 32,
  localparam int FIW = $clog2(FN),
  localparam int PIW = $clog2(PN),
  localparam int TIW = $clog2(TN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic [TIW-1:0] ld_idx,
  input  logic [AW-1:0]  ld_tag,
  input  logic [CW-1:0]  ld_chk,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [2:0]     rsp_code,
  output logic [DW-1:0]  rsp_rdata,
  output logic           cx_valid,
  input  logic           cx_ready,
  output logic           cx_encode,
  output logic [AW-1:0]  cx_addr,
  output logic [DW-1:0]  cx_wdata,
  output logic [CW-1:0]  cx_chk,
  input  logic           cr_valid,
  input  logic [DW-1:0]  cr_rdata,
  input  logic [CW-1:0]  cr_chk
);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;
  st_t st;

  logic [FN-1:0]  flt_v;
  logic [AW-1:0]  flt_a   [FN];
  logic [FIW-1:0] flt_age [FN];
  logic [PN-1:0]  pdb_v;
  logic [AW-1:0]  pdb_a   [PN];
  logic [DW-1:0]  pdb_d   [PN];
  logic [PIW-1:0] pdb_age [PN];
  logic [TN-1:0]  tag_v;
  logic [AW-1:0]  tag_a   [TN];
  logic [CW-1:0]  tag_c   [TN];

  logic           op_wr;
  logic [AW-1:0]  op_addr;
  logic [DW-1:0]  op_data;
  logic [TIW-1:0] op_idx;

  logic flt_hit, pdb_hit, tag_hit;
  logic [FIW-1:0] flt_hidx, flt_vic, flt_tidx;
  logic [PIW-1:0] pdb_hidx, pdb_vic, pdb_tidx;
  logic [TIW-1:0] tag_hidx;

  always_comb begin
    flt_hit = 1'b0; flt_hidx = '0; flt_vic = '0;
    for (int i = 0; i < FN; i++) begin
      if (flt_v[i] && flt_a[i] == req_addr) begin flt_hit = 1'b1; flt_hidx = FIW'(i); end
      if (flt_age[i] == FIW'(FN-1)) flt_vic = FIW'(i);
    end
    for (int i = FN-1; i >= 0; i--) if (!flt_v[i]) flt_vic = FIW'(i);
  end

  always_comb begin
    pdb_hit = 1'b0; pdb_hidx = '0; pdb_vic = '0;
    for (int i = 0; i < PN; i++) begin
      if (pdb_v[i] && pdb_a[i] == req_addr) begin pdb_hit = 1'b1; pdb_hidx = PIW'(i); end
      if (pdb_age[i] == PIW'(PN-1)) pdb_vic = PIW'(i);
    end
    for (int i = PN-1; i >= 0; i--) if (!pdb_v[i]) pdb_vic = PIW'(i);
  end

  always_comb begin
    tag_hit = 1'b0; tag_hidx = '0;
    for (int i = 0; i < TN; i++)
      if (tag_v[i] && tag_a[i] == req_addr) begin tag_hit = 1'b1; tag_hidx = TIW'(i); end
  end

  wire acc      = req_valid && st == IDLE;
  wire flt_use  = acc && flt_hit;
  wire buf_rd   = acc && !flt_hit && !req_write && pdb_hit;
  wire buf_wr   = acc && !flt_hit && req_write && pdb_hit;
  wire go_cx    = acc && !flt_hit && !buf_rd && tag_hit;
  wire miss     = acc && !flt_hit && !buf_rd && !tag_hit;
  wire done     = st == WAIT && cr_valid;
  wire dec_done = done && !op_wr;
  wire flt_tch  = flt_use || miss;
  wire pdb_tch  = buf_rd || buf_wr || dec_done;

  assign flt_tidx  = flt_hit ? flt_hidx : flt_vic;
  assign pdb_tidx  = dec_done ? pdb_vic : pdb_hidx;
  assign req_ready = st == IDLE;
  assign cx_valid  = st == ISSUE;
  assign cx_encode = op_wr;
  assign cx_addr   = op_addr;
  assign cx_wdata  = op_data;
  assign cx_chk    = tag_c[op_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_v <= '0;
      for (int i = 0; i < FN; i++) begin flt_a[i] <= '0; flt_age[i] <= FIW'(i); end
    end else if (flt_tch) begin
      if (miss) begin flt_v[flt_tidx] <= 1'b1; flt_a[flt_tidx] <= req_addr; end
      for (int i = 0; i < FN; i++)
        if (FIW'(i) == flt_tidx) flt_age[i] <= '0;
        else if (flt_age[i] < flt_age[flt_tidx]) flt_age[i] <= flt_age[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdb_v <= '0;
      for (int i = 0; i < PN; i++) begin pdb_a[i] <= '0; pdb_d[i] <= '0; pdb_age[i] <= PIW'(i); end
    end else if (pdb_tch) begin
      if (buf_wr) pdb_d[pdb_tidx] <= req_wdata;
      if (dec_done) begin
        pdb_v[pdb_tidx] <= 1'b1;
        pdb_a[pdb_tidx] <= op_addr;
        pdb_d[pdb_tidx] <= cr_rdata;
      end
      for (int i = 0; i < PN; i++)
        if (PIW'(i) == pdb_tidx) pdb_age[i] <= '0;
        else if (pdb_age[i] < pdb_age[pdb_tidx]) pdb_age[i] <= pdb_age[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_v <= '0;
      for (int i = 0; i < TN; i++) begin tag_a[i] <= '0; tag_c[i] <= '0; end
    end else begin
      if (done && op_wr) tag_c[op_idx] <= cr_chk;
      if (ld_valid) begin
        tag_v[ld_idx] <= 1'b1;
        tag_a[ld_idx] <= ld_tag;
        tag_c[ld_idx] <= ld_chk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; op_wr <= 1'b0; op_addr <= '0; op_data <= '0; op_idx <= '0;
    end else begin
      case (st)
        IDLE:  if (go_cx) begin
                 st <= ISSUE; op_wr <= req_write; op_addr <= req_addr;
                 op_data <= req_wdata; op_idx <= tag_hidx;
               end
        ISSUE: if (cx_ready) st <= WAIT;
        WAIT:  if (cr_valid) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_code <= '0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= flt_use || buf_rd || miss || done;
      rsp_code  <= flt_use ? 3'd0 : miss ? 3'd1 : buf_rd ? 3'd2 : op_wr ? 3'd4 : 3'd3;
      rsp_rdata <= buf_rd ? pdb_d[pdb_hidx] : dec_done ? cr_rdata : '0;
    end
  end

endmodule

module mecc_filter_checker #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [2:0]    rsp_code,
  input logic [DW-1:0] rsp_rdata,
  input logic          cx_valid,
  input logic          cx_ready,
  input logic          cx_encode,
  input logic [AW-1:0] cx_addr,
  input logic          cr_valid
);
  AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || cx_valid)); // R2
  AST_CLEAN_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code < 3'd2) |-> (rsp_rdata == '0)); // R2
  AST_RESULT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && !req_ready && !cx_valid) |=> (rsp_valid && (rsp_code == 3'd3 || rsp_code == 3'd4))); // R4
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cx_valid && !cx_ready) |=> (cx_valid && $stable(cx_addr) && $stable(cx_encode))); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cx_valid |-> !req_ready); // R9
endmodule

bind mecc_filter mecc_filter_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
  .cx_valid(cx_valid), .cx_ready(cx_ready), .cx_encode(cx_encode),
  .cx_addr(cx_addr), .cr_valid(cr_valid)
);

// File: tb/mecc_filter_bench.sv
module mecc_filter_bench;
  localparam int AW = 32, DW = 64, CW = 16, TIW = 5, LAT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [TIW-1:0] ld_idx = '0;
  logic [AW-1:0] ld_tag = '0;
  logic [CW-1:0] ld_chk = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, cx_valid, cx_encode;
  logic [2:0] rsp_code;
  logic [DW-1:0] rsp_rdata, cx_wdata;
  logic [AW-1:0] cx_addr;
  logic [CW-1:0] cx_chk;
  logic cx_ready = 1'b0, cr_valid = 1'b0;
  logic [DW-1:0] cr_rdata = '0;
  logic [CW-1:0] cr_chk = '0;

  mecc_filter u_mecc_filter (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_tag(ld_tag),
    .ld_chk(ld_chk), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata), .cx_valid(cx_valid), .cx_ready(cx_ready), .cx_encode(cx_encode),
    .cx_addr(cx_addr), .cx_wdata(cx_wdata), .cx_chk(cx_chk), .cr_valid(cr_valid),
    .cr_rdata(cr_rdata), .cr_chk(cr_chk)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0, n_cmd = 0;
  bit finished = 0;
  logic m_enc;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic [CW-1:0] m_chk;

  function automatic logic [AW-1:0] daddr(int i); return 32'h8000_0000 + AW'(i * 8); endfunction
  function automatic logic [AW-1:0] caddr(int i); return 32'h0000_1000 + AW'(i * 8); endfunction
  function automatic logic [CW-1:0] dchk(int i); return 16'h1000 + CW'(i); endfunction
  function automatic logic [CW-1:0] enc(logic [DW-1:0] d); return d[15:0] ^ d[63:48] ^ 16'h5a5a; endfunction
  function automatic logic [DW-1:0] dec(logic [AW-1:0] a, logic [CW-1:0] c); return {a, 16'h0, c}; endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : codec_model
    int wt;
    forever begin
      @(negedge clk);
      if (rst_n && cx_valid) begin
        repeat (2) @(negedge clk);
        cx_ready = 1'b1;
        m_enc = cx_encode; m_addr = cx_addr; m_wdata = cx_wdata; m_chk = cx_chk;
        n_cmd++;
        @(negedge clk);
        cx_ready = 1'b0;
        wt = LAT;
        while (wt > 0) begin @(negedge clk); wt--; end
        cr_valid = 1'b1;
        cr_rdata = m_enc ? '0 : dec(m_addr, m_chk);
        cr_chk = m_enc ? enc(m_wdata) : '0;
        @(negedge clk);
        cr_valid = 1'b0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload();
    for (int i = 1; i <= 5; i++) begin
      ld_valid = 1'b1; ld_idx = TIW'(i - 1); ld_tag = daddr(i); ld_chk = dchk(i);
      @(negedge clk);
    end
    ld_valid = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [2:0] code, output logic [DW-1:0] data,
                        output int cmds, output int lat, output bit busy_ok);
    int c0;
    c0 = n_cmd; lat = 0; busy_ok = 1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 500) begin
      if (req_ready) busy_ok = 0;
      lat++;
      @(negedge clk);
    end
    code = rsp_code; data = rsp_rdata; cmds = n_cmd - c0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 cx_valid", 64'(cx_valid), 64'd0);
  endtask

  task automatic t_clean();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    do_reset(); preload();
    access(0, caddr(0), '0, c, d, n, l, b);
    check("R2 read miss code", 64'(c), 64'd1);
    check("R2 read miss latency", 64'(l), 64'd0);
    check("R2 read miss data", d, 64'd0);
    access(0, caddr(0), '0, c, d, n, l, b);
    check("R2 read filter code", 64'(c), 64'd0);
    check("R2 no codec", 64'(n), 64'd0);
    access(1, caddr(1), 64'h1234, c, d, n, l, b);
    check("R2 write miss code", 64'(c), 64'd1);
    access(1, caddr(1), 64'h5678, c, d, n, l, b);
    check("R2 write filter code", 64'(c), 64'd0);
    check("R2 write no codec", 64'(n), 64'd0);
  endtask

  task automatic t_flt_lru();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    do_reset(); preload();
    for (int i = 1; i <= 8; i++) access(0, caddr(i), '0, c, d, n, l, b);
    access(0, caddr(1), '0, c, d, n, l, b);
    check("R3 touch C1", 64'(c), 64'd0);
    access(0, caddr(9), '0, c, d, n, l, b);
    check("R3 new C9", 64'(c), 64'd1);
    access(0, caddr(1), '0, c, d, n, l, b);
    check("R3 C1 kept", 64'(c), 64'd0);
    access(0, caddr(3), '0, c, d, n, l, b);
    check("R3 C3 kept", 64'(c), 64'd0);
    access(0, caddr(2), '0, c, d, n, l, b);
    check("R3 C2 evicted", 64'(c), 64'd1);
  endtask

  task automatic t_decode();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    do_reset(); preload();
    access(0, daddr(3), '0, c, d, n, l, b);
    check("R4 code", 64'(c), 64'd3);
    check("R4 data", d, dec(daddr(3), dchk(3)));
    check("R4 one command", 64'(n), 64'd1);
    check("R4 decode op", 64'(m_enc), 64'd0);
    check("R4 addr", 64'(m_addr), 64'(daddr(3)));
    check("R10 preloaded check bits", 64'(m_chk), 64'(dchk(3)));
    check("R9 busy while decoding", 64'(b), 64'd1);
    check("R9 latency", 64'(l > LAT), 64'd1);
  endtask

  task automatic t_buffered();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    do_reset(); preload();
    access(0, daddr(1), '0, c, d, n, l, b);
    access(0, daddr(1), '0, c, d, n, l, b);
    check("R5 code", 64'(c), 64'd2);
    check("R5 data", d, dec(daddr(1), dchk(1)));
    check("R5 no codec", 64'(n), 64'd0);
    check("R5 latency", 64'(l), 64'd0);
  endtask

  task automatic t_pdb_lru();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    do_reset(); preload();
    for (int i = 1; i <= 4; i++) access(0, daddr(i), '0, c, d, n, l, b);
    access(0, daddr(1), '0, c, d, n, l, b);
    check("R6 D1 buffered", 64'(c), 64'd2);
    access(0, daddr(5), '0, c, d, n, l, b);
    check("R6 D5 decoded", 64'(c), 64'd3);
    access(0, daddr(1), '0, c, d, n, l, b);
    check("R6 D1 kept", 64'(c), 64'd2);
    access(0, daddr(3), '0, c, d, n, l, b);
    check("R6 D3 kept", 64'(c), 64'd2);
    access(0, daddr(2), '0, c, d, n, l, b);
    check("R6 D2 evicted", 64'(c), 64'd3);
    check("R6 D2 codec used", 64'(n), 64'd1);
  endtask

  task automatic t_encode();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    logic [DW-1:0] w = 64'hdead_beef_0bad_f00d;
    do_reset(); preload();
    access(1, daddr(2), w, c, d, n, l, b);
    check("R7 code", 64'(c), 64'd4);
    check("R7 encode op", 64'(m_enc), 64'd1);
    check("R7 encode data", m_wdata, w);
    check("R9 busy while encoding", 64'(b), 64'd1);
    access(0, daddr(2), '0, c, d, n, l, b);
    check("R7 stored check bits", 64'(m_chk), 64'(enc(w)));
    check("R7 decode after encode", d, dec(daddr(2), enc(w)));
  endtask

  task automatic t_write_buf();
    logic [2:0] c; logic [DW-1:0] d; int n, l; bit b;
    logic [DW-1:0] w = 64'h0123_4567_89ab_cdef;
    do_reset(); preload();
    access(0, daddr(4), '0, c, d, n, l, b);
    access(1, daddr(4), w, c, d, n, l, b);
    check("R8 write code", 64'(c), 64'd4);
    access(0, daddr(4), '0, c, d, n, l, b);
    check("R8 read code", 64'(c), 64'd2);
    check("R8 fresh data", d, w);
    check("R8 no codec", 64'(n), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean();
    t_flt_lru();
    t_decode();
    t_buffered();
    t_pdb_lru();
    t_encode();
    t_write_buf();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule